// File: doc/BRIEF.md
# Cascadable Word-Serial Readout and Settings Chain

This block collects the conversion results of a group of sensing channels and moves them out one whole word at a time. Along the same path it receives the per-chip phase-correction and gain settings. It is a chain of `N_CH` word registers, each 10 bits wide. Word-serial data enters at the first stage and leaves from the last stage. The output of one chip wires straight to the input of the next, so any number of chips forms one long chain under a single controller.

Two control lines, both sampled through synchronizers into the system clock domain, drive the chain:

- **Strobe.** Each rising edge of the strobe acts once.
  - With the sync level high, the edge captures every channel result into its stage in parallel.
  - With the sync level low, the edge advances the chain by one word.
- **Sync.** A rising edge of sync copies the word in stage 1 into the phase register and the word in stage 2 into the gain register. To program a chip, the controller shifts in the gain word and then the phase word, then raises sync.

The word stream has no back-pressure. There is no valid or ready handshake. Every strobe edge moves the chain, and the controller owns the pacing completely.

Top module: `capsense_chain`

## Requirements
- R1: While `rst_n` is low, every chain stage, `phase_o` and `gain_o` are zero, so `ser_out_o` reads 0.
- R2: On a strobe rising edge with sync low, stage 1 takes `ser_in_i`, stage k+1 takes the old stage k, and `ser_out_o` is stage `N_CH`. Without a strobe rising edge the chain holds.
- R3: On a strobe rising edge with sync high, stage k takes channel k, which is `results_i[10k-1 : 10(k-1)]` for k = 1..`N_CH`. Readout therefore presents channel `N_CH` first.
- R4: On a sync rising edge, `phase_o` takes bits 8:0 of stage 1.
- R5: On a sync rising edge, `gain_o` takes bits 1:0 of stage 2. Bits 9:2 of that word have no effect.
- R6: `phase_o` and `gain_o` change only on a sync rising edge. Shifting and parallel loads leave them unchanged.
- R7: The effect of a strobe edge appears on `ser_out_o` at the third rising clock edge after the input rises, never earlier. A strobe held high for many cycles acts exactly once.
- R8: With one chip's `ser_out_o` wired to the next chip's `ser_in_i`, the pair behaves as a single chain of 2·`N_CH` stages. Both chips then commit their own taps on a shared sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Shift/load strobe, asynchronous to clk; acts on its rising edge |
| sync_i | input | 1 | Load-select level; its rising edge commits the settings |
| ser_in_i | input | 10 | Word-serial input (from the previous chip or the controller) |
| results_i | input | 10·N_CH | Channel results, channel k in bits 10k-1 : 10(k-1) |
| ser_out_o | output | 10 | Word-serial output, the last stage |
| phase_o | output | 9 | Committed phase-correction setting |
| gain_o | output | 2 | Committed gain setting |

## Verification
A wrong stage value is not visible right away. It reaches `ser_out_o` only after the remaining stages have shifted out, which takes up to `N_CH` strobes on one chip or 2·`N_CH` strobes across the cascade. The bench therefore compares every word of every full readout against a model of the chain.

A wrong tap shows up only after the next sync rise, as a bad `phase_o` or `gain_o`. The bench rules this out by sweeping all four gain codes and the phase extremes, with junk placed in the ignored bits.

A defect in edge detection shows at the word level: a lost or doubled shift misaligns every later output word. The bench also probes the latency at clock resolution.

// File: rtl/capsense_chain_pkg.sv
package capsense_chain_pkg;
  localparam int WORD_W  = 10;
  localparam int PHASE_W = 9;
  localparam int GAIN_W  = 2;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/capsense_bit_sync.sv
module capsense_bit_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o
);
  logic [STAGES-1:0] pipe_q [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[b] <= '0;
      else        pipe_q[b] <= {pipe_q[b][STAGES-2:0], async_i[b]};
    end
    assign level_o[b] = pipe_q[b][STAGES-1];
  end
endmodule

// File: rtl/capsense_word_chain.sv
module capsense_word_chain
  import capsense_chain_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_en,
  input  logic                   load_en,
  input  word_t                  ser_in,
  input  logic [N_CH*WORD_W-1:0] par_in,
  output word_t                  ser_out,
  output logic [PHASE_W-1:0]     ph_tap,
  output logic [GAIN_W-1:0]      gn_tap
);
  word_t stage_q [N_CH];

  for (genvar k = 0; k < N_CH; k++) begin : g_stage
    word_t upstream;
    if (k == 0) begin : g_head
      assign upstream = ser_in;
    end else begin : g_body
      assign upstream = stage_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stage_q[k] <= '0;
      else if (load_en)  stage_q[k] <= par_in[k*WORD_W +: WORD_W];
      else if (shift_en) stage_q[k] <= upstream;
    end
  end

  assign ser_out = stage_q[N_CH-1];
  assign ph_tap  = stage_q[0][PHASE_W-1:0];
  assign gn_tap  = stage_q[1][GAIN_W-1:0];
endmodule

// File: rtl/capsense_cfg_regs.sv
module capsense_cfg_regs
  import capsense_chain_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [PHASE_W-1:0] ph_tap,
  input  logic [GAIN_W-1:0]  gn_tap,
  output logic [PHASE_W-1:0] phase,
  output logic [GAIN_W-1:0]  gain
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      gain  <= '0;
    end else if (commit) begin
      phase <= ph_tap;
      gain  <= gn_tap;
    end
  end
endmodule

// File: rtl/capsense_chain.sv
module capsense_chain
  import capsense_chain_pkg::*;
#(
  parameter int N_CH        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strobe_i,
  input  logic                   sync_i,
  input  logic [WORD_W-1:0]      ser_in_i,
  input  logic [N_CH*WORD_W-1:0] results_i,
  output logic [WORD_W-1:0]      ser_out_o,
  output logic [PHASE_W-1:0]     phase_o,
  output logic [GAIN_W-1:0]      gain_o
);
  localparam int CTL_W   = 2;
  localparam int CTL_STB = 0;
  localparam int CTL_SYN = 1;

  logic [CTL_W-1:0]   ctl_lvl;
  logic [CTL_W-1:0]   ctl_lvl_d;
  logic [CTL_W-1:0]   ctl_rise;
  logic               strobe_rise;
  logic               sync_lvl;
  logic               sync_rise;
  logic [PHASE_W-1:0] ph_tap;
  logic [GAIN_W-1:0]  gn_tap;

  capsense_bit_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sync_i, strobe_i}),
    .level_o (ctl_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_lvl_d <= '0;
    else        ctl_lvl_d <= ctl_lvl;
  end

  assign ctl_rise    = ctl_lvl & ~ctl_lvl_d;
  assign strobe_rise = ctl_rise[CTL_STB];
  assign sync_rise   = ctl_rise[CTL_SYN];
  assign sync_lvl    = ctl_lvl[CTL_SYN];

  capsense_word_chain #(.N_CH(N_CH)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (strobe_rise & ~sync_lvl),
    .load_en  (strobe_rise & sync_lvl),
    .ser_in   (ser_in_i),
    .par_in   (results_i),
    .ser_out  (ser_out_o),
    .ph_tap   (ph_tap),
    .gn_tap   (gn_tap)
  );

  capsense_cfg_regs u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (sync_rise),
    .ph_tap (ph_tap),
    .gn_tap (gn_tap),
    .phase  (phase_o),
    .gain   (gain_o)
  );
endmodule

// File: rtl/capsense_chain_chk.sv
module capsense_chain_chk
  import capsense_chain_pkg::*;
#(
  parameter int N_CH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   strobe_rise,
  input logic                   sync_lvl,
  input logic                   sync_rise,
  input logic [WORD_W-1:0]      ser_in,
  input logic [N_CH*WORD_W-1:0] results,
  input logic [WORD_W-1:0]      ser_out,
  input logic [PHASE_W-1:0]     ph_tap,
  input logic [GAIN_W-1:0]      gn_tap,
  input logic [PHASE_W-1:0]     phase,
  input logic [GAIN_W-1:0]      gain
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_rise |=> $stable(ser_out)); // R2
  AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise && !sync_lvl |=> ph_tap == $past(ser_in[PHASE_W-1:0])); // R2
  AST_SHIFT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise && !sync_lvl |=> gn_tap == $past(ph_tap[GAIN_W-1:0])); // R2
  AST_LOAD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise && sync_lvl |=> ser_out == $past(results[N_CH*WORD_W-1 -: WORD_W])); // R3
  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise && sync_lvl |=> ph_tap == $past(results[PHASE_W-1:0])); // R3
  AST_PHASE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> phase == $past(ph_tap)); // R4
  AST_GAIN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> gain == $past(gn_tap)); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_rise |=> $stable(phase) && $stable(gain)); // R6
  AST_SINGLE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> !strobe_rise); // R7
endmodule

bind capsense_chain capsense_chain_chk #(.N_CH(N_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .strobe_rise (strobe_rise),
  .sync_lvl    (sync_lvl),
  .sync_rise   (sync_rise),
  .ser_in      (ser_in_i),
  .results     (results_i),
  .ser_out     (ser_out_o),
  .ph_tap      (ph_tap),
  .gn_tap      (gn_tap),
  .phase       (phase_o),
  .gain        (gain_o)
);

// File: tb/capsense_chain_tb_top.sv
module capsense_chain_tb_top;
  localparam int N = 4;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strb = 1'b0;
  logic sync = 1'b0;
  logic [W-1:0] din = '0;
  logic [N*W-1:0] res_a = '0;
  logic [N*W-1:0] res_b = '0;
  logic [W-1:0] out_a, out_b;
  logic [8:0] ph_a, ph_b;
  logic [1:0] gn_a, gn_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] m [2*N];
  logic [8:0] eph [2];
  logic [1:0] egn [2];
  logic sync_m = 1'b0;

  always #10 clk = ~clk;

  capsense_chain #(.N_CH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(strb), .sync_i(sync),
    .ser_in_i(din), .results_i(res_a),
    .ser_out_o(out_a), .phase_o(ph_a), .gain_o(gn_a));

  capsense_chain #(.N_CH(N)) nxt_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(strb), .sync_i(sync),
    .ser_in_i(out_a), .results_i(res_b),
    .ser_out_o(out_b), .phase_o(ph_b), .gain_o(gn_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic settle;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk(tag,  32'(out_a), 32'(m[N-1]));
    chk("R8", 32'(out_b), 32'(m[2*N-1]));
    chk("R4", 32'(ph_a), 32'(eph[0]));
    chk("R4", 32'(ph_b), 32'(eph[1]));
    chk("R5", 32'(gn_a), 32'(egn[0]));
    chk("R5", 32'(gn_b), 32'(egn[1]));
  endtask

  task automatic model_shift(input logic [W-1:0] w);
    for (int p = 2*N-1; p > 0; p--) m[p] = m[p-1];
    m[0] = w;
  endtask

  task automatic do_shift(input logic [W-1:0] w);
    @(negedge clk) din = w; strb = 1'b1;
    settle;
    strb = 1'b0;
    settle;
    model_shift(w);
    check_all("R2");
  endtask

  task automatic do_load;
    @(negedge clk) strb = 1'b1;
    settle;
    strb = 1'b0;
    settle;
    for (int k = 0; k < N; k++) begin
      m[k]   = res_a[k*W +: W];
      m[N+k] = res_b[k*W +: W];
    end
    check_all("R3");  // R6: settings unchanged by the load
  endtask

  task automatic set_sync(input logic v);
    @(negedge clk) sync = v;
    if (v && !sync_m) begin
      eph[0] = m[0][8:0];   egn[0] = m[1][1:0];
      eph[1] = m[N][8:0];   egn[1] = m[N+1][1:0];
    end
    sync_m = v;
    settle;
    check_all("R6");
  endtask

  task automatic model_reset;
    for (int p = 0; p < 2*N; p++) m[p] = '0;
    eph[0] = '0; eph[1] = '0; egn[0] = '0; egn[1] = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [W-1:0] prev;
    model_reset();
    repeat (4) @(negedge clk);
    chk("R1", 32'(out_a), 0); chk("R1", 32'(out_b), 0);
    chk("R1", 32'(ph_a), 0);  chk("R1", 32'(gn_b), 0);
    rst_n = 1'b1;
    settle;

    // R7: latency and single action for a held strobe
    for (int j = 0; j < N-1; j++) do_shift(W'(10'h100 + j));
    prev = m[N-1];
    @(negedge clk) din = 10'h2AB; strb = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R7", 32'(out_a), 32'(prev));
    model_shift(10'h2AB);
    @(posedge clk); @(negedge clk);
    chk("R7", 32'(out_a), 32'(m[N-1]));
    repeat (10) @(negedge clk);
    chk("R7", 32'(out_a), 32'(m[N-1]));
    strb = 1'b0;
    settle;
    check_all("R2");

    // Sweep: settings pushed through the cascade double as readout shifts
    for (int i = 0; i < 8; i++) begin
      logic [8:0] pa, pb;
      logic [1:0] ga, gb;
      pa = (i == 0) ? 9'h1FF : 9'((i*71 + 3) % 512);
      pb = (i == 1) ? 9'h000 : 9'((i*113 + 40) % 512);
      ga = 2'(i % 4);
      gb = 2'((i + 1) % 4);
      for (int j = 1; j <= 2*N; j++) begin
        logic [W-1:0] w;
        if (j == N-1)        w = {8'h5A ^ 8'(i), gb};   // R5 junk upper bits
        else if (j == N)     w = {1'b1, pb};
        else if (j == 2*N-1) w = {~8'(i), ga};
        else if (j == 2*N)   w = {1'b0, pa};
        else                 w = W'(j*97 + i*13);
        do_shift(w);
      end
      set_sync(1'b1);
      chk("R4", 32'(ph_a), 32'(pa)); chk("R4", 32'(ph_b), 32'(pb));
      chk("R5", 32'(gn_a), 32'(ga)); chk("R5", 32'(gn_b), 32'(gb));
      for (int k = 0; k < N; k++) begin
        res_a[k*W +: W] = (i == 1) ? 10'h3FF : W'((k+1)*37 + i*101 + 5);
        res_b[k*W +: W] = (i == 1) ? 10'h000 : W'(((k+1)*59) ^ (i*23));
      end
      do_load();
      set_sync(1'b0);
    end
    for (int j = 0; j < 2*N; j++) do_shift(W'(j));

    // R1: reset in mid-run
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", 32'(out_a), 0); chk("R1", 32'(out_b), 0);
    chk("R1", 32'(ph_a), 0);  chk("R1", 32'(ph_b), 0);
    chk("R1", 32'(gn_a), 0);  chk("R1", 32'(gn_b), 0);
    rst_n = 1'b1;
    model_reset();
    settle;
    do_shift(10'h0C3);
    report();
  end
endmodule